// File: doc/BRIEF.md
# Four-Channel Serial Audio Bus Master

This block runs a short serial audio link on which it is always the master. From the system clock it derives a bit clock. It also marks the end of every sampling period with a one-bit identification strobe. Each period lasts 144 bit clocks: 4.608 MHz divided by a 32 kHz sample rate. The first 64 bit clocks carry four 16-bit channels, and the remaining 80 are idle.

Incoming bits are shifted in on the serial data input. Once all 64 have arrived, the four received words are presented in parallel together with a single-cycle valid pulse. A second serial line plays back four parallel 16-bit test words over the same 64 data slots. This lets an internal data stream be observed on a pin.

The divider parameter sets the bit clock. Each half of the bit clock lasts `DIV_HALF` system clocks, so the bit clock is the system clock divided by 2·`DIV_HALF`.

Top module: `quad_audio_bus_master`

## Requirements
- R1: While `rst` is high, and in the cycle it is released, `bclk_o`, `id_o`, `sdo_o` and `rx_valid_o` are 0 and all four received words are zero.
- R2: `bclk_o` is a square wave whose high and low phases each last exactly `DIV_HALF` system clocks. Its first rise comes `DIV_HALF` cycles after reset is released.
- R3: A sampling period is `PERIOD_BITS` (144) bit clocks. Slot 0 starts at the first falling edge of `bclk_o` after reset. Every later slot starts at a falling edge, and slots 0 to 63 carry data.
- R4: `sdi_i` is sampled at the rising edge of `bclk_o` in data slots. The first 16 slots form channel 0, then channels 1, 2 and 3 follow, each word MSB first.
- R5: `rx_valid_o` is high for one system clock once per period, in the cycle after the rising edge of slot 63. All four words update in that same cycle and hold until the next pulse.
- R6: `id_o` is high for exactly slot 64, one full bit clock starting at the falling edge that ends slot 63, and is low in every other slot.
- R7: `sdo_o` carries the test words in slots 0 to 63 with the same order as the input (channel 0 first, MSB first). It changes on falling edges of `bclk_o` and is 0 in slots 64 to 143.
- R8: The test words are captured at the start of slot 0. Changes to `tst_ch*_i` during a period have no effect on `sdo_o` until the next period.
- R9: `sdi_i` is ignored in idle slots 64 to 143; the received words depend only on the data slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sdi_i | input | 1 | Serial audio data in |
| bclk_o | output | 1 | Bit clock |
| id_o | output | 1 | End-of-period identification strobe |
| sdo_o | output | 1 | Serial test data out |
| rx_ch0_o | output | 16 | Received channel 0 |
| rx_ch1_o | output | 16 | Received channel 1 |
| rx_ch2_o | output | 16 | Received channel 2 |
| rx_ch3_o | output | 16 | Received channel 3 |
| rx_valid_o | output | 1 | One-cycle pulse: new words present |
| tst_ch0_i | input | 16 | Test word for slots 0–15 |
| tst_ch1_i | input | 16 | Test word for slots 16–31 |
| tst_ch2_i | input | 16 | Test word for slots 32–47 |
| tst_ch3_i | input | 16 | Test word for slots 48–63 |

## Verification
The bench drives random values on `sdi_i` during the idle slots. A design that keeps shifting after slot 63 would therefore return corrupted words. It also changes the test words mid-period, which exposes a design that reads them live instead of latching them at slot 0.

Patterns of all zeros, all ones, alternating bits and lone end bits catch swapped channel order, reversed bit order and words off by one slot. The strobe and the valid pulse are tracked slot by slot. A strobe or pulse one slot early or late, or a valid pulse that repeats, shows up as a mismatch. Bit-clock phase lengths are timed in system clocks, which catches a wrong divider count.

// File: rtl/quad_audio_bus_master.sv
module quad_audio_bus_master #(
  parameter int CH_BITS     = 16,
  parameter int PERIOD_BITS = 144,
  parameter int DIV_HALF    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sdi_i,
  output logic               bclk_o,
  output logic               id_o,
  output logic               sdo_o,
  output logic [CH_BITS-1:0] rx_ch0_o,
  output logic [CH_BITS-1:0] rx_ch1_o,
  output logic [CH_BITS-1:0] rx_ch2_o,
  output logic [CH_BITS-1:0] rx_ch3_o,
  output logic               rx_valid_o,
  input  logic [CH_BITS-1:0] tst_ch0_i,
  input  logic [CH_BITS-1:0] tst_ch1_i,
  input  logic [CH_BITS-1:0] tst_ch2_i,
  input  logic [CH_BITS-1:0] tst_ch3_i
);
  localparam int FB = 4 * CH_BITS;
  localparam int CW = $clog2(PERIOD_BITS);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DW-1:0] div_q;
  logic          bclk_q;
  logic [CW-1:0] slot_q;
  logic [FB-1:0] rx_sr, rx_hold, tx_sr;
  logic          vld_q;

  wire tick      = div_q == DW'(DIV_HALF - 1);
  wire rise      = tick & ~bclk_q;
  wire fall      = tick & bclk_q;
  wire in_data   = slot_q < CW'(FB);
  wire last_slot = slot_q == CW'(PERIOD_BITS - 1);
  wire [FB-1:0] rx_next = {rx_sr[FB-2:0], sdi_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      bclk_q  <= 1'b0;
      slot_q  <= CW'(PERIOD_BITS - 1);
      rx_sr   <= '0;
      rx_hold <= '0;
      tx_sr   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) bclk_q <= ~bclk_q;
      if (rise && in_data) begin
        rx_sr <= rx_next;
        if (slot_q == CW'(FB - 1)) begin
          rx_hold <= rx_next;
          vld_q   <= 1'b1;
        end
      end
      if (fall) begin
        slot_q <= last_slot ? '0 : slot_q + 1'b1;
        tx_sr  <= last_slot ? {tst_ch0_i, tst_ch1_i, tst_ch2_i, tst_ch3_i}
                            : {tx_sr[FB-2:0], 1'b0};
      end
    end
  end

  assign bclk_o     = bclk_q;
  assign id_o       = slot_q == CW'(FB);
  assign sdo_o      = in_data & tx_sr[FB-1];
  assign rx_valid_o = vld_q;
  assign rx_ch0_o   = rx_hold[4*CH_BITS-1:3*CH_BITS];
  assign rx_ch1_o   = rx_hold[3*CH_BITS-1:2*CH_BITS];
  assign rx_ch2_o   = rx_hold[2*CH_BITS-1:CH_BITS];
  assign rx_ch3_o   = rx_hold[CH_BITS-1:0];

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);
  // R5
  valid_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $rose(bclk_o));
  // R6
  id_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(id_o) |-> $fell(bclk_o));
  // R7
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    id_o |-> !sdo_o);
  // R6
  id_valid_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !(id_o && rx_valid_o));
endmodule

// File: tb/test_quad_audio_bus_master.sv
module test_quad_audio_bus_master;
  localparam int DIV  = 2;
  localparam int PER  = 144;
  localparam int NFR  = 40;

  logic clk = 1'b0, rst = 1'b1, sdi = 1'b0;
  logic bclk, id, sdo, vld;
  logic [15:0] rx0, rx1, rx2, rx3;
  logic [15:0] t0, t1, t2, t3;

  int checks = 0, fails = 0;
  int pos = PER - 1, fnum = 0, vtotal = 0, vframe = 0;
  logic [63:0] fr_in = '0, exp_tx = '0, tnext = '0;

  always #10 clk = ~clk;

  quad_audio_bus_master #(.CH_BITS(16), .PERIOD_BITS(PER), .DIV_HALF(DIV)) i_quad_audio_bus_master (
    .clk(clk), .rst(rst), .sdi_i(sdi), .bclk_o(bclk), .id_o(id), .sdo_o(sdo),
    .rx_ch0_o(rx0), .rx_ch1_o(rx1), .rx_ch2_o(rx2), .rx_ch3_o(rx3), .rx_valid_o(vld),
    .tst_ch0_i(t0), .tst_ch1_i(t1), .tst_ch2_i(t2), .tst_ch3_i(t3));

  function automatic logic [63:0] pattern(int n, int salt);
    case (n)
      0: return 64'h0;
      1: return '1;
      2: return {4{16'hAAAA}} ^ (salt[0] ? '1 : '0);
      3: return 64'h8000_0001_8000_0001 ^ {32'h0, salt};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  function automatic logic exp_sdo(int p, logic [63:0] w);
    return (p < 64) ? w[63-p] : 1'b0;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (slot %0d)", req, act, exp, pos);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Stimulus aligned to the bench's own slot count
  initial begin
    forever begin
      @(negedge bclk);
      pos = (pos == PER - 1) ? 0 : pos + 1;
      if (pos == 0) begin
        fr_in  = pattern(fnum, fnum);
        exp_tx = {t0, t1, t2, t3};
        fnum++;
      end
      if (pos == 30) {t0, t1, t2, t3} = {$urandom, $urandom};
      if (pos == 100) begin
        tnext = pattern(fnum + 1, 7);
        {t0, t1, t2, t3} = tnext;
      end
      sdi = (pos < 64) ? fr_in[63-pos] : 1'(($urandom % 2));
    end
  end

  // Monitor between clock edges
  logic prev_b = 1'b0;
  int   run = 0;
  bit   seen_edge = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (bclk !== prev_b) begin
          if (seen_edge) check("R2 phase length", 64'(run), 64'(DIV));
          seen_edge = 1;
          run = 1;
        end else run++;
        if (bclk && !prev_b) begin
          check("R6 id strobe", 64'(id), 64'(pos == 64));
          check("R7 R8 sdo", 64'(sdo), 64'(exp_sdo(pos, exp_tx)));
          if (pos == 64) begin
            check("R5 one valid per period", 64'(vframe), 64'(fnum > 0));
            vframe = 0;
          end
          if (pos == 100 && fnum > 0)
            check("R5 words hold", {rx0, rx1, rx2, rx3}, fr_in);
        end
        if (vld) begin
          vtotal++; vframe++;
          check("R3 valid slot", 64'(pos), 64'd63);
          check("R4 R9 words", {rx0, rx1, rx2, rx3}, fr_in);
        end
        prev_b = bclk;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    {t0, t1, t2, t3} = 64'hF00D_0000_1234_FFFF;
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {60'h0, bclk, id, sdo, vld}, 64'h0);
    check("R1 reset words", {rx0, rx1, rx2, rx3}, 64'h0);
    @(posedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle", {62'h0, bclk, vld}, 64'h0);
    repeat (DIV - 1) @(negedge clk);
    check("R2 first rise", 64'(bclk), 64'd1);
    wait (vtotal == NFR);
    repeat (PER * 2 * DIV / 2) @(negedge clk);
    check("R5 total valid", 64'(vtotal), 64'(NFR));
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end
endmodule